// File: doc/BRIEF.md
# In-Order Receive Sequence Checker

This block is the receive half of a reliable transport for a single connection. Each arriving packet comes with its sequence number, a code for where it sits in its message, and a valid strobe. The checker keeps the sequence number it expects next. A packet that carries exactly that number is accepted: a write enable goes to the memory writer and the expectation moves forward by one. A packet that is ahead of the expectation means that something was lost. The packet is dropped and the block asks for a negative acknowledgement that names the missing number. A packet that is behind the expectation is a duplicate. It is dropped and the block asks the sender to be reminded how far the stream has got.

Acknowledgements are cumulative. One ACK request names the highest sequence number received in order, and that covers every earlier packet. An ACK is requested when the final packet of a message is accepted. It is also requested after a programmable number of accepted packets, so that long messages get periodic acknowledgement. The block only raises one-cycle request strobes with a sequence number. Forming the response packets is done elsewhere.

Top module: `rx_seq_check`

## Requirements
- R1: While `rst_n` is low, `init_seq` is loaded as the expected number and all outputs are 0. The first packet carrying `init_seq` is accepted.
- R2: A valid packet whose number equals the expected number raises `wr_en` for one cycle on the clock edge after it is presented. The expected number then advances by one.
- R3: A valid packet whose number is ahead of the expected number is not written. Instead `nak_req` is raised with `resp_seq` equal to the expected (missing) number, and the expected number is unchanged.
- R4: Only one NAK is issued per gap. Further ahead-of-expected packets produce no strobe until an in-order packet is accepted.
- R5: After a NAK, the resent expected number is accepted normally. That acceptance re-arms the NAK, so a later gap is reported again.
- R6: A valid packet whose number is behind the expected number is not written. `ack_req` is raised with `resp_seq` equal to the expected number minus one, modulo 2^24.
- R7: Position codes are 00 first, 01 middle, 10 last and 11 only. Accepting an in-order packet with code 10 or 11 raises `ack_req` with `resp_seq` equal to that packet's number.
- R8: When `ack_every` is nonzero, an ACK naming the accepted packet is raised when the in-order packets accepted since the last in-order ACK reach `ack_every`. The count restarts at every in-order ACK, and a value of 0 disables the periodic ACK. Duplicate ACKs do not touch the count.
- R9: Numbers are 24 bits and wrap from 0xFFFFFF to 0. Let d = (packet − expected) mod 2^24. The packet is ahead when 1 ≤ d < 2^23 and behind when d ≥ 2^23.
- R10: When a message end and the periodic count fall on the same accepted packet, exactly one ACK is raised and the count restarts. `ack_req` and `nak_req` are never high together.
- R11: A cycle without `pkt_valid` produces all strobes low on the next cycle. `resp_seq` is 0 whenever neither request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_seq | input | 24 | Starting expected number, loaded during reset |
| ack_every | input | 8 | Accepted-packet count between periodic ACKs, 0 = off |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_seq | input | 24 | Packet sequence number |
| pkt_pos | input | 2 | Position in message (00 first, 01 middle, 10 last, 11 only) |
| wr_en | output | 1 | Accept strobe toward the memory writer |
| ack_req | output | 1 | Cumulative ACK request |
| nak_req | output | 1 | NAK request |
| resp_seq | output | 24 | Number carried by the ACK or NAK |

## Verification
Two ACK triggers can fall on the same accepted packet: the end of a message and the periodic count. The bench sets the ACK interval so that the counter reaches its limit exactly on a last-packet code. It then checks that a single ACK request comes out with that packet's number, and that the next periodic ACK is a full interval later. Gap and duplicate reporting also share `resp_seq` but fall in different cycles. The reference model is compared every clock, so it judges which strobe wins, and a double strobe is reported.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;
  localparam int SEQ_W = 24;
  localparam int CNT_W = 8;

  typedef logic [SEQ_W-1:0] seq_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    POS_FIRST  = 2'b00,
    POS_MIDDLE = 2'b01,
    POS_LAST   = 2'b10,
    POS_ONLY   = 2'b11
  } pos_e;

  typedef enum logic [1:0] {
    CLS_IDLE,
    CLS_INORDER,
    CLS_AHEAD,
    CLS_BEHIND
  } cls_e;

  // Modulo distance from expected to received.
  function automatic seq_t seq_dist(input seq_t rcvd, input seq_t want);
    return rcvd - want;
  endfunction

  // Half-range window: top bit of the distance set means behind.
  function automatic cls_e seq_classify(input logic vld, input seq_t rcvd, input seq_t want);
    seq_t d;
    d = seq_dist(rcvd, want);
    if (!vld)                 return CLS_IDLE;
    else if (d == '0)         return CLS_INORDER;
    else if (!d[SEQ_W-1])     return CLS_AHEAD;
    else                      return CLS_BEHIND;
  endfunction

  // Last and only codes share bit 1.
  function automatic logic ends_message(input logic [1:0] pos);
    return pos[1];
  endfunction
endpackage

// File: rtl/rx_seq_classify.sv
module rx_seq_classify
  import rx_seq_pkg::*;
(
  input  logic vld,
  input  seq_t rcvd,
  input  seq_t want,
  output cls_e cls
);
  assign cls = seq_classify(vld, rcvd, want);
endmodule

// File: rtl/rx_ack_pacer.sv
module rx_ack_pacer
  import rx_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic msg_end,
  input  cnt_t ack_every,
  output logic fire
);
  cnt_t cnt_q;
  cnt_t cnt_inc;
  logic count_hit;

  assign cnt_inc   = cnt_q + 1'b1;
  assign count_hit = (ack_every != '0) && (cnt_inc >= ack_every);
  assign fire      = accept && (msg_end || count_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (fire)   cnt_q <= '0;
    else if (accept) cnt_q <= cnt_inc;
  end

  // R8 / R10: any in-order ACK restarts the interval
  assert_fire_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == '0));
endmodule

// File: rtl/rx_seq_check.sv
module rx_seq_check
  import rx_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEQ_W-1:0] init_seq,
  input  logic [CNT_W-1:0] ack_every,
  input  logic             pkt_valid,
  input  logic [SEQ_W-1:0] pkt_seq,
  input  logic [1:0]       pkt_pos,
  output logic             wr_en,
  output logic             ack_req,
  output logic             nak_req,
  output logic [SEQ_W-1:0] resp_seq
);
  seq_t exp_q;
  logic nak_sent_q;
  cls_e cls;

  // Named internal events for assertions
  logic ev_accept, ev_gap, ev_dup, ev_nak, ev_pace_ack;

  rx_seq_classify u_cls (
    .vld  (pkt_valid),
    .rcvd (pkt_seq),
    .want (exp_q),
    .cls  (cls)
  );

  assign ev_accept = (cls == CLS_INORDER);
  assign ev_gap    = (cls == CLS_AHEAD);
  assign ev_dup    = (cls == CLS_BEHIND);
  assign ev_nak    = ev_gap && !nak_sent_q;

  rx_ack_pacer u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (ev_accept),
    .msg_end   (ends_message(pkt_pos)),
    .ack_every (ack_every),
    .fire      (ev_pace_ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q      <= init_seq;
      nak_sent_q <= 1'b0;
      wr_en      <= 1'b0;
      ack_req    <= 1'b0;
      nak_req    <= 1'b0;
      resp_seq   <= '0;
    end else begin
      wr_en    <= ev_accept;
      ack_req  <= ev_pace_ack || ev_dup;
      nak_req  <= ev_nak;
      resp_seq <= '0;
      if (ev_accept) begin
        exp_q      <= exp_q + 1'b1;
        nak_sent_q <= 1'b0;
        if (ev_pace_ack) resp_seq <= pkt_seq;
      end else if (ev_nak) begin
        nak_sent_q <= 1'b1;
        resp_seq   <= exp_q;
      end else if (ev_dup) begin
        resp_seq   <= exp_q - 1'b1;
      end
    end
  end

  assert_write_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (exp_q == $past(exp_q) + 1'b1));

  assert_nak_names_missing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nak_req |-> (resp_seq == exp_q && !wr_en));

  assert_one_nak_per_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nak_req |=> !nak_req);

  assert_dup_acks_previous_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !wr_en) |-> (resp_seq == exp_q - 1'b1));

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_req, nak_req}));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pkt_valid) |-> !(wr_en || ack_req || nak_req));
endmodule

// File: tb/rx_seq_check_tb_top.sv
module rx_seq_check_tb_top;
  localparam int SW = 24;
  localparam int CW = 8;
  localparam longint MASK = (64'd1 << SW) - 1;
  localparam longint HALF = 64'd1 << (SW - 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [SW-1:0] init_seq;
  logic [CW-1:0] ack_every;
  logic          pkt_valid;
  logic [SW-1:0] pkt_seq;
  logic [1:0]    pkt_pos;
  logic          wr_en, ack_req, nak_req;
  logic [SW-1:0] resp_seq;

  rx_seq_check dut_i (
    .clk(clk), .rst_n(rst_n), .init_seq(init_seq), .ack_every(ack_every),
    .pkt_valid(pkt_valid), .pkt_seq(pkt_seq), .pkt_pos(pkt_pos),
    .wr_en(wr_en), .ack_req(ack_req), .nak_req(nak_req), .resp_seq(resp_seq)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural reference state
  longint m_exp;
  longint m_cnt;
  bit     m_naked;

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic do_reset(input longint start, input int every);
    @(negedge clk);
    rst_n = 1'b0; init_seq = SW'(start); ack_every = CW'(every);
    pkt_valid = 1'b0; pkt_seq = '0; pkt_pos = 2'b00;
    @(negedge clk); @(negedge clk);
    chk("R1", "wr_en in reset", longint'(wr_en), 0);
    chk("R1", "ack_req in reset", longint'(ack_req), 0);
    chk("R1", "nak_req in reset", longint'(nak_req), 0);
    chk("R1", "resp_seq in reset", longint'(resp_seq), 0);
    rst_n = 1'b1;
    m_exp = start & MASK; m_cnt = 0; m_naked = 0;
  endtask

  task automatic step(input bit v, input longint s, input int p, input string req);
    bit e_wr, e_ack, e_nak;
    longint e_seq, d;
    e_wr = 0; e_ack = 0; e_nak = 0; e_seq = 0;
    pkt_valid = v; pkt_seq = SW'(s); pkt_pos = 2'(p);
    if (v) begin
      d = (s - m_exp) & MASK;
      if (d == 0) begin
        e_wr = 1;
        m_cnt = m_cnt + 1;
        if (p >= 2 || (ack_every != 0 && m_cnt >= longint'(ack_every))) begin
          e_ack = 1; e_seq = s & MASK; m_cnt = 0;
        end
        m_exp = (m_exp + 1) & MASK;
        m_naked = 0;
      end else if (d < HALF) begin
        if (!m_naked) begin
          e_nak = 1; e_seq = m_exp; m_naked = 1;
        end
      end else begin
        e_ack = 1; e_seq = (m_exp - 1) & MASK;
      end
    end
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(req, "wr_en", longint'(wr_en), longint'(e_wr));
    chk(req, "ack_req", longint'(ack_req), longint'(e_ack));
    chk(req, "nak_req", longint'(nak_req), longint'(e_nak));
    chk(req, "resp_seq", longint'(resp_seq), e_seq);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Phase A: start 5000, ACK every 4 accepted packets
    do_reset(5000, 4);
    step(1, 5000, 0, "R1");
    step(1, 5001, 1, "R2");
    step(1, 5002, 1, "R2");
    step(1, 5003, 1, "R8");          // periodic ACK 5003
    step(0, 0, 0, "R11");
    step(1, 5005, 1, "R3");          // gap, NAK 5004
    step(1, 5006, 1, "R4");          // silent
    step(1, 5007, 1, "R4");          // silent
    step(1, 5004, 1, "R5");          // resend accepted
    step(1, 5005, 1, "R5");
    step(1, 5006, 2, "R7");          // last -> ACK 5006
    step(1, 5001, 0, "R6");          // duplicate -> ACK 5006
    step(1, 5009, 0, "R5");          // new gap reported again
    step(1, 5007, 0, "R2");
    step(1, 5008, 1, "R2");
    step(1, 5009, 1, "R2");
    step(1, 5010, 2, "R10");         // count reaches 4 on last
    step(1, 5011, 1, "R10");
    step(1, 5012, 1, "R10");
    step(1, 5013, 1, "R10");
    step(1, 5014, 1, "R10");         // periodic ACK a full interval later
    step(1, 5015 + HALF, 0, "R9");   // behind by window -> dup ACK
    step(1, 5015 + HALF - 1, 0, "R9"); // ahead -> NAK 5015
    step(1, 5015, 3, "R7");          // only -> ACK
    // Phase B: wrap, periodic ACK disabled
    do_reset(24'hFFFFFE, 0);
    step(1, 24'hFFFFFE, 0, "R9");
    step(1, 24'hFFFFFF, 1, "R9");
    step(1, 0, 1, "R9");
    step(1, 1, 1, "R8");
    step(1, 2, 1, "R8");
    step(1, 24'hFFFFFF, 1, "R6");    // duplicate across wrap -> ACK 2
    step(1, 5, 1, "R3");             // NAK 3
    step(1, 3, 2, "R7");
    step(0, 0, 0, "R11");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule